// File: doc/BRIEF.md
# Core-Local Machine Timer with 64-bit Compare

This block is the timer that sits next to a processor core. It keeps a 64-bit time count as two 32-bit halves and a 64-bit compare value, also as two halves. When the count reaches the compare value, the block raises a machine timer pending flag. It also holds a single software interrupt bit. Firmware reaches all of these state words through a word-indexed read/write bus: writes take one cycle and reads are combinational.

The count advances by one on every cycle in which the tick enable is high. A carry out of the low half bumps the high half. The reached test works half by half: the high halves are compared first, and the low halves decide only when the high halves are equal. A compare value of all zeros means the timer interrupt is switched off. The pending flag is sticky. Other logic outside the block drops it with a clear strobe, and the flag comes back on the next cycle if the count is still at or past the compare value.

Top module: `core_timer`

## Requirements
- R1: After reset, the time count, both compare halves, the software bit and both pending outputs are zero, and every register offset reads 0.
- R2: In a cycle with tick_en high and no time write, the low time half increases by one. With tick_en low and no time write, both time halves hold.
- R3: When a tick takes the low half from 0xFFFFFFFF to 0, the high half increases by one in the same edge.
- R4: A bus write to either time half loads bus_wdata into that half, and no tick is applied to the count in that cycle.
- R5: The word offsets are 0 = software bit (bit 0, upper bits read 0), 1 = compare low, 2 = compare high, 3 = time low, 4 = time high. Offsets 5 to 7 read 0, and writes to them change nothing.
- R6: With a non-zero compare, timer_pend becomes 1 at the edge after a cycle in which time_hi > cmp_hi, or time_hi == cmp_hi and time_lo >= cmp_lo.
- R7: While both compare halves are zero, timer_pend is never raised, whatever the time count.
- R8: Once set, timer_pend stays 1 until timer_clr is applied, even if the compare later stops holding.
- R9: timer_clr forces timer_pend to 0 at the next edge. If the condition still holds, timer_pend returns to 1 one edge later.
- R10: A write to a compare half takes effect at its edge. The condition is evaluated against the new value in the following cycle.
- R11: soft_pend equals bit 0 of the last value written to offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the time count this cycle |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| timer_clr | input | 1 | Clear the timer pending flag |
| timer_pend | output | 1 | Machine timer pending |
| soft_pend | output | 1 | Software interrupt pending |

## Verification
The bench goes after the carry from the low half into the high half. A design that drops the carry shows a count that jumps backwards by 2^32. It probes compare values whose halves straddle the time value. A design that compares each half on its own raises the flag too early or misses it when the high half is larger and the low half is smaller. The bench also holds an all-zero compare against a huge count, where a missing disable would fire at once. It applies the clear while the condition still holds, where a design that gives priority to setting the flag would never drop it. Finally, it writes to time while ticking, where a design that lets the tick win would be off by one.

// File: rtl/clt_pkg.sv
package clt_pkg;
  localparam int unsigned CLT_HALF_W = 32;
  localparam int unsigned CLT_ADDR_W = 3;
  localparam int unsigned CLT_HALVES = 2;

  typedef logic [CLT_HALF_W-1:0] half_t;

  typedef enum logic [CLT_ADDR_W-1:0] {
    OFF_SOFT    = 3'd0,
    OFF_CMP_LO  = 3'd1,
    OFF_CMP_HI  = 3'd2,
    OFF_TIME_LO = 3'd3,
    OFF_TIME_HI = 3'd4
  } clt_reg_e;

  // Half-by-half reached test: high halves decide unless equal.
  function automatic logic half_reached(half_t t_hi, half_t t_lo, half_t c_hi, half_t c_lo);
    return (t_hi > c_hi) || ((t_hi == c_hi) && (t_lo >= c_lo));
  endfunction

  function automatic logic all_zero(half_t a, half_t b);
    return (a == '0) && (b == '0);
  endfunction
endpackage

// File: rtl/clt_time_counter.sv
module clt_time_counter
  import clt_pkg::*;
#(
  parameter int unsigned W = CLT_HALF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         ld_lo,
  input  logic         ld_hi,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] time_lo,
  output logic [W-1:0] time_hi,
  output logic         lo_wrap
);
  logic [W:0] lo_sum;
  logic       adv;

  assign lo_sum  = {1'b0, time_lo} + (W+1)'(1);
  assign adv     = tick_en && !ld_lo && !ld_hi;
  assign lo_wrap = adv && lo_sum[W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_lo <= '0;
      time_hi <= '0;
    end else if (ld_lo) begin
      time_lo <= ld_val;
    end else if (ld_hi) begin
      time_hi <= ld_val;
    end else if (adv) begin
      time_lo <= lo_sum[W-1:0];
      if (lo_sum[W]) time_hi <= time_hi + W'(1);
    end
  end

  a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> time_lo == $past(time_lo) + W'(1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld_lo && !ld_hi) |=> ($stable(time_lo) && $stable(time_hi)));
  a_r3_carry: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |=> (time_lo == '0 && time_hi == $past(time_hi) + W'(1)));
  a_r4_load_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> (time_lo == $past(ld_val) && $stable(time_hi)));
endmodule

// File: rtl/clt_cmp_bank.sv
module clt_cmp_bank
  import clt_pkg::*;
#(
  parameter int unsigned W = CLT_HALF_W,
  parameter int unsigned N = CLT_HALVES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr_en,
  input  logic [W-1:0]        wr_val,
  output logic [N-1:0][W-1:0] cmp
);
  for (genvar g = 0; g < N; g++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n)       cmp[g] <= '0;
      else if (wr_en[g]) cmp[g] <= wr_val;
    end

    a_r10_cmp_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[g] |=> cmp[g] == $past(wr_val));
  end
endmodule

// File: rtl/clt_cmp_eval.sv
module clt_cmp_eval
  import clt_pkg::*;
(
  input  half_t time_lo,
  input  half_t time_hi,
  input  half_t cmp_lo,
  input  half_t cmp_hi,
  output logic  cmp_zero,
  output logic  hit
);
  assign cmp_zero = all_zero(cmp_lo, cmp_hi);
  assign hit      = !cmp_zero && half_reached(time_hi, time_lo, cmp_hi, cmp_lo);
endmodule

// File: rtl/core_timer.sv
module core_timer
  import clt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  bus_we,
  input  logic [CLT_ADDR_W-1:0] bus_addr,
  input  logic [CLT_HALF_W-1:0] bus_wdata,
  output logic [CLT_HALF_W-1:0] bus_rdata,
  input  logic                  timer_clr,
  output logic                  timer_pend,
  output logic                  soft_pend
);
  localparam int unsigned W = CLT_HALF_W;
  localparam int unsigned N = CLT_HALVES;

  logic                wr_soft, wr_tlo, wr_thi;
  logic [N-1:0]        wr_cmp;
  logic [N-1:0][W-1:0] cmp;
  logic [W-1:0]        time_lo, time_hi;
  logic                lo_wrap, cmp_zero, hit;

  assign wr_soft   = bus_we && (bus_addr == OFF_SOFT);
  assign wr_cmp[0] = bus_we && (bus_addr == OFF_CMP_LO);
  assign wr_cmp[1] = bus_we && (bus_addr == OFF_CMP_HI);
  assign wr_tlo    = bus_we && (bus_addr == OFF_TIME_LO);
  assign wr_thi    = bus_we && (bus_addr == OFF_TIME_HI);

  clt_time_counter #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .ld_lo(wr_tlo), .ld_hi(wr_thi), .ld_val(bus_wdata),
    .time_lo(time_lo), .time_hi(time_hi), .lo_wrap(lo_wrap)
  );

  clt_cmp_bank #(.W(W), .N(N)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cmp), .wr_val(bus_wdata), .cmp(cmp)
  );

  clt_cmp_eval u_eval (
    .time_lo(time_lo), .time_hi(time_hi), .cmp_lo(cmp[0]), .cmp_hi(cmp[1]),
    .cmp_zero(cmp_zero), .hit(hit)
  );

  // Clear wins this cycle; a persisting condition re-sets the flag next cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)         timer_pend <= 1'b0;
    else if (timer_clr) timer_pend <= 1'b0;
    else if (hit)       timer_pend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       soft_pend <= 1'b0;
    else if (wr_soft) soft_pend <= bus_wdata[0];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_SOFT:    bus_rdata = {{(W-1){1'b0}}, soft_pend};
      OFF_CMP_LO:  bus_rdata = cmp[0];
      OFF_CMP_HI:  bus_rdata = cmp[1];
      OFF_TIME_LO: bus_rdata = time_lo;
      OFF_TIME_HI: bus_rdata = time_hi;
      default:     bus_rdata = '0;
    endcase
  end

  a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !timer_clr) |=> timer_pend);
  a_r7_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_zero && !timer_pend) |=> !timer_pend);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_pend && !timer_clr) |=> timer_pend);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    timer_clr |=> !timer_pend);
  a_r11_soft: assert property (@(posedge clk) disable iff (!rst_n)
    wr_soft |=> soft_pend == $past(bus_wdata[0]));
  a_r3_carry_seen: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |=> time_lo == '0);
endmodule

// File: tb/core_timer_bench.sv
module core_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, bus_we, timer_clr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        timer_pend, soft_pend;

  always #10 clk = ~clk;

  core_timer u_core_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timer_clr(timer_clr), .timer_pend(timer_pend), .soft_pend(soft_pend)
  );

  logic [63:0] m_time, m_cmp;
  logic        m_soft, m_pend;
  int          n_vec = 0, n_bad = 0;
  string       cur_req = "R1";

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_soft};
      3'd1: return m_cmp[31:0];
      3'd2: return m_cmp[63:32];
      3'd3: return m_time[31:0];
      3'd4: return m_time[63:32];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic reached64(logic [63:0] t, logic [63:0] c);
    return (c != 64'd0) && (t >= c);
  endfunction

  task automatic cyc(logic we, logic [2:0] a, logic [31:0] d, logic tk, logic clr);
    logic nxt;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk; timer_clr = clr;
    #1;
    if (!we) chk(cur_req, "rdata", bus_rdata, model_read(a));
    nxt = clr ? 1'b0 : (m_pend | reached64(m_time, m_cmp));
    if (we && a == 3'd3)      m_time[31:0]  = d;
    else if (we && a == 3'd4) m_time[63:32] = d;
    else if (tk)              m_time = m_time + 64'd1;
    if (we && a == 3'd1) m_cmp[31:0]  = d;
    if (we && a == 3'd2) m_cmp[63:32] = d;
    if (we && a == 3'd0) m_soft = d[0];
    m_pend = nxt;
    @(posedge clk);
    #1;
    chk(cur_req, "timer_pend", {31'd0, timer_pend}, {31'd0, m_pend});
    chk(cur_req == "R5" ? "R11" : cur_req, "soft_pend", {31'd0, soft_pend}, {31'd0, m_soft});
  endtask

  task automatic rd(logic [2:0] a);
    cyc(1'b0, a, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(64'd20 * 64'd150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; tick_en = 1'b0; bus_we = 1'b0; bus_addr = 3'd0;
    bus_wdata = 32'd0; timer_clr = 1'b0;
    m_time = 64'd0; m_cmp = 64'd0; m_soft = 1'b0; m_pend = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state at every offset and on both outputs
    for (int a = 0; a < 5; a++) begin
      bus_addr = 3'(a);
      #1 chk("R1", "reset rdata", bus_rdata, 32'd0);
    end
    chk("R1", "reset timer_pend", {31'd0, timer_pend}, 32'd0);
    chk("R1", "reset soft_pend", {31'd0, soft_pend}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    // R5: map, unused offsets, soft bit width (R11)
    cur_req = "R5";
    wr(3'd1, 32'h1111_0001); wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd5, 32'hDEAD_BEEF); wr(3'd6, 32'h1234_5678); wr(3'd7, 32'hFFFF_FFFF);
    for (int a = 0; a < 8; a++) rd(3'(a));
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0);
    wr(3'd0, 32'hFFFF_FFFE); rd(3'd0);
    wr(3'd0, 32'h0000_0001); rd(3'd0);

    // R2: tick steps and holds
    cur_req = "R2";
    for (int i = 0; i < 5; i++) cyc(1'b0, 3'd3, 32'd0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) rd(3'd3);

    // R3: carry out of low half
    cur_req = "R3";
    wr(3'd3, 32'hFFFF_FFFD); wr(3'd4, 32'd7);
    for (int i = 0; i < 4; i++) cyc(1'b0, 3'd4, 32'd0, 1'b1, 1'b0);
    rd(3'd3); rd(3'd4);

    // R4: time write during tick suppresses the tick
    cur_req = "R4";
    cyc(1'b1, 3'd3, 32'h0000_0100, 1'b1, 1'b0); rd(3'd3);
    cyc(1'b1, 3'd4, 32'h0000_0002, 1'b1, 1'b0); rd(3'd3); rd(3'd4);

    // R7: zero compare with a huge count
    cur_req = "R7";
    wr(3'd1, 32'd0); wr(3'd2, 32'd0);
    wr(3'd4, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFF0);
    for (int i = 0; i < 6; i++) cyc(1'b0, 3'd3, 32'd0, 1'b1, 1'b0);

    // R6 and R10: reach an exact compare value
    cur_req = "R6";
    wr(3'd4, 32'd0); wr(3'd3, 32'd0);
    wr(3'd2, 32'd1); wr(3'd1, 32'd10);
    cur_req = "R10";
    wr(3'd4, 32'd1); wr(3'd3, 32'd5);
    cur_req = "R6";
    for (int i = 0; i < 8; i++) cyc(1'b0, 3'd3, 32'd0, 1'b1, 1'b0);
    // high half larger, low half smaller
    cyc(1'b0, 3'd0, 32'd0, 1'b0, 1'b1);
    wr(3'd3, 32'd0); wr(3'd4, 32'd0); wr(3'd1, 32'hFFFF_0000);
    cyc(1'b0, 3'd0, 32'd0, 1'b0, 1'b1);
    rd(3'd0); wr(3'd4, 32'd2); rd(3'd0); rd(3'd0);

    // R8: sticky after the compare moves away
    cur_req = "R8";
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) rd(3'd1);

    // R9: clear with condition false, then with condition true
    cur_req = "R9";
    cyc(1'b0, 3'd0, 32'd0, 1'b0, 1'b1); rd(3'd0); rd(3'd0);
    wr(3'd2, 32'd0); wr(3'd1, 32'd1);
    rd(3'd0);
    cyc(1'b0, 3'd0, 32'd0, 1'b0, 1'b1); rd(3'd0); rd(3'd0);
    cyc(1'b0, 3'd0, 32'd0, 1'b0, 1'b1); cyc(1'b0, 3'd0, 32'd0, 1'b0, 1'b1); rd(3'd0);

    // Random mix around the compare and the wrap
    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      logic [63:0] tgt;
      r = $urandom % 16;
      tgt = m_time + 64'($urandom % 40);
      case (r)
        0: cyc(1'b1, 3'd1, tgt[31:0], 1'b0, 1'b0);
        1: cyc(1'b1, 3'd2, tgt[63:32], 1'b1, 1'b0);
        2: cyc(1'b1, 3'd3, 32'hFFFF_FFF0 + ($urandom % 16), 1'b0, 1'b0);
        3: cyc(1'b1, 3'd4, m_time[63:32] + ($urandom % 2), 1'b1, 1'b0);
        4: cyc(1'b0, 3'($urandom % 8), 32'd0, 1'b1, 1'b1);
        5: cyc(1'b1, 3'd0, $urandom, 1'b1, 1'b0);
        6: cyc(1'b1, 3'($urandom % 8), $urandom, ($urandom % 2) == 0, 1'b0);
        default: cyc(1'b0, 3'($urandom % 8), 32'd0, ($urandom % 4) != 0, 1'b0);
      endcase
    end

    summary();
    $finish;
  end
endmodule